// File: doc/BRIEF.md
# Multi-lane DDR ADC readout

This block runs one acquisition cycle on a multi-channel successive-approximation converter that presents its results on several serial data lanes. A one-cycle start request opens the cycle. The block first raises the convert strobe `conv_n` for a fixed number of clock cycles. The converter takes its sample on the falling edge of that strobe. The block then waits a fixed conversion time. After that it drives a gated serial clock, `sck`, at half the system clock rate, together with a launched enable, `sck_en`.

The converter sends back a copy of the serial clock and of the enable. Both copies lag the launched signals by the board round trip. Every level change of the returned clock carries one new bit on each lane, so data moves on both edges. The block oversamples the returned signals in the system clock domain. It shifts one bit per lane for each returned edge. It knows that capture is over when the returned enable falls. Only then does it copy the assembled words to its outputs and raise `done`. Each lane carries a fixed group of adjacent channels, and the words are signed two's complement.

The block is used by pulsing `start` while `done` is high and reading `sample_o` once `done` is high again.

Top module: `adc_ddr_readout`

## Requirements
- R1: After reset, `done` is 1, `conv_n`, `sck` and `sck_en` are 0, and every word of `sample_o` is 0.
- R2: A `start` sampled while `done` is high makes `done` low in the next cycle. From that same cycle, `conv_n` is high for exactly T_CNVH cycles and then falls.
- R3: After `conv_n` falls, `sck_en` stays low for exactly T_CONV cycles. It then stays high for exactly W*CH/L cycles. `sck` is low in the first cycle of that window, toggles every cycle and shows W*CH/(2*L) rising edges. `sck` is never high while `sck_en` is low.
- R4: Each level change of `ret_clk`, whether rising or falling, shifts exactly one bit from every lane into that lane's assembly register. A pattern of alternating bits is therefore received intact.
- R5: Lane l carries channels l*CPL to l*CPL+CPL-1, where CPL = CH/L. The highest-numbered of these channels comes first, and each word is sent most significant bit first. Channel c appears at `sample_o[c*W +: W]`.
- R6: Words are W-bit two's complement values and are passed through unchanged, including the most negative value, the most positive value and -1.
- R7: The result does not depend on the round-trip delay of `ret_clk` and `ret_en`. `done` stays low, and `sample_o` keeps its previous words, until the fall of `ret_en` has been seen. All words change together, in the cycle in which `done` rises.
- R8: A `start` received while `done` is low is ignored. Exactly one strobe pulse and one serial burst occur per accepted start.
- R9: While `done` is high and no start is given, `sample_o` holds its value, whatever the converter inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run an acquisition |
| ret_clk | input | 1 | Serial clock as returned by the converter |
| ret_en | input | 1 | Serial clock enable as returned by the converter |
| sdo_i | input | LANES | Serial data, one bit per lane |
| conv_n | output | 1 | Convert strobe; the converter samples on its falling edge |
| sck | output | 1 | Gated serial clock to the converter |
| sck_en | output | 1 | Launched serial clock enable |
| done | output | 1 | High when idle and the words are valid |
| sample_o | output | CHANNELS*WIDTH | Assembled words, channel c at bits [c*W +: W] |

## Verification
The hardest situation to reach is the interval after the launched enable has dropped but before its returned copy has fallen. In that interval the block must keep `done` low and keep the old words. With a short round trip this interval lasts only a cycle or two. The bench therefore models the converter with a run-time selectable delay tap and sets it to nine cycles. It samples `done` and `sample_o` at the exact cycle `sck_en` falls, and only afterwards checks that all words update together when `done` rises.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNVH,
        ST_CONV,
        ST_SHIFT,
        ST_WAITR,
        ST_LOAD
    } rd_state_e;

    // Events seen on the returned clock and enable after resynchronisation
    typedef struct packed {
        logic edge_stb;
        logic en_fall;
    } ret_evt_t;

    function automatic int unsigned cnt_bits(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int unsigned T_CNVH = 4,
    parameter int unsigned T_CONV = 57,
    parameter int unsigned N_EDGE = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ret_fall,
    output logic conv_n,
    output logic sck,
    output logic sck_en,
    output logic done,
    output logic load
);
    localparam int unsigned CW = cnt_bits(T_CNVH, T_CONV, N_EDGE);
    localparam logic [CW-1:0] CNVH_LAST = CW'(T_CNVH - 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(T_CONV - 1);
    localparam logic [CW-1:0] EDGE_LAST = CW'(N_EDGE - 1);

    rd_state_e      st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_CNVH;
                        cnt <= CNVH_LAST;
                    end
                end
                ST_CNVH: begin
                    if (cnt == '0) begin
                        st  <= ST_CONV;
                        cnt <= CONV_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt == '0) begin
                        st  <= ST_SHIFT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt == EDGE_LAST) begin
                        st  <= ST_WAITR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAITR: begin
                    if (ret_fall) st <= ST_LOAD;
                end
                ST_LOAD:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign conv_n = (st == ST_CNVH);
    assign sck_en = (st == ST_SHIFT);
    assign sck    = sck_en & cnt[0];
    assign done   = (st == ST_IDLE);
    assign load   = (st == ST_LOAD);

    p_done_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    p_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_en) |-> !$past(conv_n));

    p_edge_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT) |-> (cnt <= EDGE_LAST));

    p_sck_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !sck_en |-> !sck);

    p_pulse_from_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_n) |-> $past(done));

    p_done_after_load_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(load));

endmodule

// File: rtl/adc_rd_retsync.sv
module adc_rd_retsync
    import adc_rd_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ret_clk,
    input  logic             ret_en,
    input  logic [LANES-1:0] sdo_i,
    output ret_evt_t         evt,
    output logic [LANES-1:0] bits
);
    logic clk_q, clk_p, en_q, en_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            clk_p <= 1'b0;
            en_q  <= 1'b0;
            en_p  <= 1'b0;
            bits  <= '0;
        end else begin
            clk_q <= ret_clk;
            clk_p <= clk_q;
            en_q  <= ret_en;
            en_p  <= en_q;
            bits  <= sdo_i;
        end
    end

    // Both edge directions of the returned clock produce a capture strobe
    assign evt.edge_stb = clk_q ^ clk_p;
    assign evt.en_fall  = en_p & ~en_q;

    p_single_fall_r7: assert property (@(posedge clk) disable iff (rst)
        evt.en_fall |=> !evt.en_fall);

endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
    parameter int unsigned LW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic          bit_i,
    output logic [LW-1:0] sr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (stb) begin
            sr <= {sr[LW-2:0], bit_i};
        end
    end

    p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(sr));

endmodule

// File: rtl/adc_ddr_readout.sv
module adc_ddr_readout
    import adc_rd_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned LANES    = 4,
    parameter int unsigned T_CNVH   = 4,
    parameter int unsigned T_CONV   = 57
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        ret_clk,
    input  logic                        ret_en,
    input  logic [LANES-1:0]            sdo_i,
    output logic                        conv_n,
    output logic                        sck,
    output logic                        sck_en,
    output logic                        done,
    output logic [CHANNELS*WIDTH-1:0]   sample_o
);
    localparam int unsigned CPL    = CHANNELS / LANES;
    localparam int unsigned LW     = CPL * WIDTH;
    localparam int unsigned N_EDGE = LW;

    ret_evt_t         evt;
    logic [LANES-1:0] bits;
    logic             load;
    logic [LW-1:0]    lane_sr [LANES];

    adc_rd_seq #(
        .T_CNVH (T_CNVH),
        .T_CONV (T_CONV),
        .N_EDGE (N_EDGE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ret_fall (evt.en_fall),
        .conv_n   (conv_n),
        .sck      (sck),
        .sck_en   (sck_en),
        .done     (done),
        .load     (load)
    );

    adc_rd_retsync #(
        .LANES (LANES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .ret_clk (ret_clk),
        .ret_en  (ret_en),
        .sdo_i   (sdo_i),
        .evt     (evt),
        .bits    (bits)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        adc_rd_lane #(
            .LW (LW)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .stb   (evt.edge_stb),
            .bit_i (bits[l]),
            .sr    (lane_sr[l])
        );
    end

    // A lane register already holds its channels in ascending slot order
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
        end else if (load) begin
            for (int l = 0; l < LANES; l++) begin
                sample_o[l*LW +: LW] <= lane_sr[l];
            end
        end
    end

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(sample_o));

    p_words_frozen_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (!done && !load) |=> $stable(sample_o));

endmodule

// File: tb/adc_ddr_readout_bench.sv
module adc_ddr_readout_bench;
    localparam int W      = 16;
    localparam int CH     = 8;
    localparam int L      = 4;
    localparam int T_CNVH = 4;
    localparam int T_CONV = 57;
    localparam int CPL    = CH / L;
    localparam int LW     = CPL * W;
    localparam int N_SCK  = W * CH / (2 * L);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ret_clk = 1'b0;
    logic ret_en = 1'b0;
    logic [L-1:0] sdo = '0;
    logic conv_n, sck, sck_en, done;
    logic [CH*W-1:0] sample_o;

    always #10 clk = ~clk;

    adc_ddr_readout #(
        .WIDTH(W), .CHANNELS(CH), .LANES(L), .T_CNVH(T_CNVH), .T_CONV(T_CONV)
    ) u_adc_ddr_readout (
        .clk(clk), .rst(rst), .start(start), .ret_clk(ret_clk), .ret_en(ret_en),
        .sdo_i(sdo), .conv_n(conv_n), .sck(sck), .sck_en(sck_en), .done(done),
        .sample_o(sample_o)
    );

    // Converter model: delayed clock/enable echo, one bit per returned edge
    logic [CH*W-1:0] adc_val = '0;
    int              rtt = 1;
    logic [15:0]     sck_dl = '0;
    logic [15:0]     en_dl = '0;
    logic            m_conv_prev = 1'b0;
    logic [LW-1:0]   lsr [L];

    initial for (int l = 0; l < L; l++) lsr[l] = '0;

    always @(posedge clk) begin
        sck_dl      <= {sck_dl[14:0], sck};
        en_dl       <= {en_dl[14:0], sck_en};
        ret_clk     <= sck_dl[rtt-1];
        ret_en      <= en_dl[rtt-1];
        m_conv_prev <= conv_n;
        if (m_conv_prev && !conv_n) begin
            for (int l = 0; l < L; l++) lsr[l] <= adc_val[l*LW +: LW];
        end else if (sck_dl[rtt-1] != ret_clk) begin
            for (int l = 0; l < L; l++) begin
                sdo[l] <= lsr[l][LW-1];
                lsr[l] <= lsr[l] << 1;
            end
        end
    end

    // Port monitor, sampled mid-cycle
    int   cyc = 0, conv_hi = 0, conv_rises = 0, en_cyc = 0, sck_rises = 0, bad_sck = 0;
    int   t_cfall = 0, t_erise = 0;
    logic sck_at_erise = 1'b0;
    logic mp_conv = 1'b0, mp_en = 1'b0, mp_sck = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (conv_n) conv_hi <= conv_hi + 1;
        if (conv_n && !mp_conv) conv_rises <= conv_rises + 1;
        if (!conv_n && mp_conv) t_cfall <= cyc;
        if (sck_en) en_cyc <= en_cyc + 1;
        if (sck_en && !mp_en) begin
            t_erise      <= cyc;
            sck_at_erise <= sck;
        end
        if (sck && !mp_sck) sck_rises <= sck_rises + 1;
        if (sck && !sck_en) bad_sck <= bad_sck + 1;
        mp_conv <= conv_n;
        mp_en   <= sck_en;
        mp_sck  <= sck;
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_words(input string req, input logic [CH*W-1:0] exp);
        for (int c = 0; c < CH; c++) begin
            chk(sample_o[c*W +: W] == exp[c*W +: W], req, $sformatf("word %0d", c),
                longint'($signed(sample_o[c*W +: W])), longint'($signed(exp[c*W +: W])));
        end
    endtask

    // One acquisition, with the timing and hand-off checks shared by all scenarios
    task automatic run_conv(input int r, input logic [CH*W-1:0] vals, input bit poke);
        int c0_hi, c0_rise, c0_en, c0_sck, c0_bad, i;
        logic [CH*W-1:0] old;
        logic en_prev;
        bit seen_fall;
        rtt = r;
        adc_val = vals;
        @(negedge clk);
        old = sample_o;
        c0_hi = conv_hi; c0_rise = conv_rises; c0_en = en_cyc;
        c0_sck = sck_rises; c0_bad = bad_sck;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R2", "done after start", done, 0);
        en_prev = 1'b0;
        seen_fall = 1'b0;
        i = 0;
        while (!done && i < 2000) begin
            @(negedge clk);
            i++;
            start = poke && (i == 20 || i == 70);
            if (en_prev && !sck_en && !seen_fall) begin
                seen_fall = 1'b1;
                chk(done == 1'b0, "R7", "done at launched enable fall", done, 0);
                chk(sample_o == old, "R7", "words frozen before return", 0, 0);
            end
            en_prev = sck_en;
        end
        start = 1'b0;
        chk(done == 1'b1, "R7", "done returns", done, 1);
        @(negedge clk);
        chk(conv_hi - c0_hi == T_CNVH, "R2", "strobe high cycles", conv_hi - c0_hi, T_CNVH);
        chk(conv_rises - c0_rise == 1, "R8", "strobe pulses", conv_rises - c0_rise, 1);
        chk(t_erise - t_cfall == T_CONV, "R3", "conversion gap", t_erise - t_cfall, T_CONV);
        chk(en_cyc - c0_en == 2 * N_SCK, "R3", "enable cycles", en_cyc - c0_en, 2 * N_SCK);
        chk(sck_rises - c0_sck == N_SCK, "R3", "sck rises", sck_rises - c0_sck, N_SCK);
        chk(sck_at_erise == 1'b0, "R3", "sck low first", sck_at_erise, 0);
        chk(bad_sck == c0_bad, "R3", "sck without enable", bad_sck - c0_bad, 0);
    endtask

    task automatic t_reset();
        chk(done == 1'b1, "R1", "done", done, 1);
        chk(conv_n == 1'b0, "R1", "conv_n", conv_n, 0);
        chk(sck == 1'b0, "R1", "sck", sck, 0);
        chk(sck_en == 1'b0, "R1", "sck_en", sck_en, 0);
        chk(sample_o == '0, "R1", "words", 0, 0);
    endtask

    task automatic t_basic();
        logic [CH*W-1:0] v;
        for (int c = 0; c < CH; c++) v[c*W +: W] = W'(c * 16'h1111 + 16'h0203);
        run_conv(1, v, 1'b0);
        chk_words("R5", v);
    endtask

    task automatic t_signed();
        logic [CH*W-1:0] v;
        for (int c = 0; c < CH; c++) begin
            case (c % 4)
                0:       v[c*W +: W] = 16'h8000;
                1:       v[c*W +: W] = 16'h7FFF;
                2:       v[c*W +: W] = 16'hFFFF;
                default: v[c*W +: W] = W'(-12345 + c);
            endcase
        end
        run_conv(2, v, 1'b0);
        chk_words("R6", v);
        chk($signed(sample_o[0 +: W]) == -32768, "R6", "most negative",
            longint'($signed(sample_o[0 +: W])), -32768);
    endtask

    task automatic t_delay();
        logic [CH*W-1:0] v;
        for (int c = 0; c < CH; c++) v[c*W +: W] = (c % 2 == 0) ? 16'hAAAA : 16'h5555;
        v[3*W +: W] = 16'h0001;
        run_conv(9, v, 1'b0);
        chk_words("R4", v);
        chk_words("R7", v);
    endtask

    task automatic t_busy();
        logic [CH*W-1:0] v;
        for (int c = 0; c < CH; c++) v[c*W +: W] = W'(16'hF00D ^ (c << 9));
        run_conv(3, v, 1'b1);
        chk_words("R8", v);
    endtask

    task automatic t_idle_hold();
        logic [CH*W-1:0] held;
        held = sample_o;
        adc_val = ~adc_val;
        repeat (40) @(negedge clk);
        chk(done == 1'b1, "R9", "done stays high", done, 1);
        chk(sample_o == held, "R9", "words held while idle", 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_basic();
        t_signed();
        t_delay();
        t_busy();
        t_idle_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual expired expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

endmodule